// File: doc/BRIEF.md
# Subgraph LUT configuration generator

This block builds the lookup-table contents for a programmable carry unit. It does not evaluate the subgraph on data. It runs the subgraph's short instruction sequence on truth-table bit-vectors instead. A meta register file holds one pattern for each architectural register. A register that the subgraph reads as an input is first seeded with the pattern of a free variable. With N variables, pattern bit j holds the value that the variable takes in row j of the truth table. Logical instructions combine the patterns of their source registers bit by bit. An addition also records its generate and propagate patterns in the next carry stage. It then writes sum-without-carry XOR the pattern of that stage's carry variable into its destination.

Instructions arrive one per cycle through a valid/ready stream. A transfer takes place on a rising edge where `ins_valid` and `ins_ready` are both high. The sender must hold its fields stable while `ins_ready` is low. `ins_ready` drops for exactly one cycle, the cycle in which `done` is high. A terminating instruction names two output registers. One cycle after it is accepted, `done` pulses and the configuration words appear. They are held until the next pulse. If any instruction in the subgraph breaks a rule, the pulse carries `err` and all-zero configuration words.

Top module: `lut_cfg_gen`

## Requirements
- R1: Out of reset, `ins_ready` is 1, `done` and `err` are 0, and every configuration output is zero.
- R2: An instruction is consumed only on an edge where `ins_valid` and `ins_ready` are both high. `ins_ready` is 0 exactly in the cycle where `done` is 1. An instruction held during that cycle is consumed once, on the following edge.
- R3: Opcode 4 (seed) writes the pattern of the next unused input variable into `ins_dst`. Input variables are numbered upward from 0. With four variables the first four seeds yield 16'hAAAA, 16'hCCCC, 16'hF0F0 and 16'hFF00. Variable k has pattern bit j equal to bit k of j.
- R4: Opcodes 0, 1 and 2 write the bitwise AND, OR and XOR of the `ins_src_a` and `ins_src_b` patterns into `ins_dst`.
- R5: Opcode 3 (add) numbers carry stages from 0 in order of arrival. Stage n stores g = A AND B and p = A XOR B. The destination receives A XOR B XOR the carry pattern. Stage n uses variable NUM_VARS-1-n as its carry, so with four variables stage 0 uses 16'hFF00 and stage 1 uses 16'hF0F0.
- R6: Opcode 5 (end) pulses `done` for one cycle on the edge after it is accepted. In that pulse, `cfg_out0` and `cfg_out1` carry the patterns of `ins_src_a` and `ins_src_b`. `cfg_g` and `cfg_p` carry stage n in bits [n*PAT_W +: PAT_W], with zero for unused stages. These outputs hold until the next pulse. The next subgraph starts with no defined registers and no used variables or stages.
- R7: An instruction that reads a register that is neither seeded nor written earlier in the same subgraph is an error. This includes the end instruction's output registers.
- R8: A seed or an add is an error when seeds plus adds already equal NUM_VARS. An add is also an error when MAX_ADD stages are already used.
- R9: Opcodes 6 and 7 are errors.
- R10: After an error, the remaining instructions of the subgraph change nothing. The next `done` pulse carries `err`=1 with all configuration outputs zero, and the following subgraph starts free of the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Instruction can be consumed |
| ins_op | input | 3 | 0 AND, 1 OR, 2 XOR, 3 add, 4 seed, 5 end |
| ins_dst | input | $clog2(NUM_REGS) | Destination register |
| ins_src_a | input | $clog2(NUM_REGS) | First source, or first output register on end |
| ins_src_b | input | $clog2(NUM_REGS) | Second source, or second output register on end |
| done | output | 1 | One-cycle configuration-ready pulse |
| err | output | 1 | The last finished subgraph broke a rule |
| cfg_out0 | output | 2**NUM_VARS | Output LUT pattern for the first output register |
| cfg_out1 | output | 2**NUM_VARS | Output LUT pattern for the second output register |
| cfg_g | output | MAX_ADD*2**NUM_VARS | Generate patterns, one per carry stage |
| cfg_p | output | MAX_ADD*2**NUM_VARS | Propagate patterns, one per carry stage |

## Verification
The bench builds the block with NUM_VARS=4, MAX_ADD=2 and NUM_REGS=16. The patterns are then 16 bits wide, which keeps every expected configuration a short hex constant that can be worked out by hand. At these values, two adds plus two inputs exactly fill the variable budget. A third add hits the stage limit before the variable limit does, and a fifth seed overruns the variables, so both limit errors can be reached separately. The carry patterns of both stages can also be told apart from the input patterns.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ORR  = 3'd1,
    OP_EOR  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SEED = 3'd4,
    OP_END  = 3'd5
  } lcg_op_e;
endpackage

// File: rtl/lcg_var_patterns.sv
module lcg_var_patterns #(
  parameter int NUM_VARS = 4,
  parameter int PAT_W    = 16
) (
  output logic [NUM_VARS-1:0][PAT_W-1:0] pats
);
  // Row j of the truth table: variable k takes bit k of j
  for (genvar k = 0; k < NUM_VARS; k++) begin : g_var
    for (genvar j = 0; j < PAT_W; j++) begin : g_row
      assign pats[k][j] = ((j >> k) % 2) == 1;
    end
  end
endmodule

// File: rtl/lcg_meta_regfile.sv
module lcg_meta_regfile #(
  parameter int NUM_REGS = 16,
  parameter int PAT_W    = 16,
  parameter int RW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [RW-1:0]    waddr,
  input  logic [PAT_W-1:0] wdata,
  input  logic [RW-1:0]    raddr_a,
  input  logic [RW-1:0]    raddr_b,
  output logic [PAT_W-1:0] rdata_a,
  output logic [PAT_W-1:0] rdata_b,
  output logic             rdef_a,
  output logic             rdef_b
);
  logic [PAT_W-1:0]    mem [NUM_REGS];
  logic [NUM_REGS-1:0] defd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   defd <= '0;
    else if (clr) defd <= '0;
    else if (we)  defd[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
  assign rdef_a  = defd[raddr_a];
  assign rdef_b  = defd[raddr_b];
endmodule

// File: rtl/lcg_meta_fu.sv
module lcg_meta_fu
  import lcg_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic [2:0]       op,
  input  logic [PAT_W-1:0] a,
  input  logic [PAT_W-1:0] b,
  input  logic [PAT_W-1:0] cin,
  output logic [PAT_W-1:0] res,
  output logic [PAT_W-1:0] gen,
  output logic [PAT_W-1:0] prop
);
  always_comb begin
    gen  = a & b;
    prop = a ^ b;
    case (op)
      OP_AND:  res = a & b;
      OP_ORR:  res = a | b;
      OP_EOR:  res = a ^ b;
      OP_ADD:  res = prop ^ cin;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/lut_cfg_gen.sv
module lut_cfg_gen
  import lcg_pkg::*;
#(
  parameter int NUM_VARS = 4,
  parameter int MAX_ADD  = 2,
  parameter int NUM_REGS = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ins_valid,
  output logic                                ins_ready,
  input  logic [2:0]                          ins_op,
  input  logic [$clog2(NUM_REGS)-1:0]         ins_dst,
  input  logic [$clog2(NUM_REGS)-1:0]         ins_src_a,
  input  logic [$clog2(NUM_REGS)-1:0]         ins_src_b,
  output logic                                done,
  output logic                                err,
  output logic [(1<<NUM_VARS)-1:0]            cfg_out0,
  output logic [(1<<NUM_VARS)-1:0]            cfg_out1,
  output logic [MAX_ADD*(1<<NUM_VARS)-1:0]    cfg_g,
  output logic [MAX_ADD*(1<<NUM_VARS)-1:0]    cfg_p
);
  localparam int RW    = $clog2(NUM_REGS);
  localparam int PAT_W = 1 << NUM_VARS;
  localparam int CW    = $clog2(NUM_VARS + 1);
  localparam int VW    = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1;
  localparam logic [CW:0]   NV_L = (CW+1)'(NUM_VARS);
  localparam logic [CW-1:0] MA_L = CW'(MAX_ADD);

  logic [NUM_VARS-1:0][PAT_W-1:0] pats;
  logic [PAT_W-1:0] rd_a, rd_b, fu_res, fu_gen, fu_prop, wdata, seed_pat, cin_pat;
  logic             def_a, def_b, fire, is_end, op_err, wr, we;
  logic [CW-1:0]    in_cnt, add_cnt;
  logic [CW:0]      used;
  logic [VW-1:0]    cin_idx;
  logic             done_q, err_q, err_o;
  logic [MAX_ADD-1:0][PAT_W-1:0] g_q, p_q, go_q, po_q;
  logic [PAT_W-1:0] out0_q, out1_q;

  lcg_var_patterns #(.NUM_VARS(NUM_VARS), .PAT_W(PAT_W)) u_pats (.pats(pats));

  assign fire      = ins_valid && !done_q;
  assign ins_ready = !done_q;
  assign is_end    = (ins_op == OP_END);
  assign used      = {1'b0, in_cnt} + {1'b0, add_cnt};
  assign seed_pat  = pats[in_cnt[VW-1:0]];

  always_comb cin_idx = VW'(NUM_VARS - 1 - int'(add_cnt));
  assign cin_pat = pats[cin_idx];

  lcg_meta_regfile #(.NUM_REGS(NUM_REGS), .PAT_W(PAT_W), .RW(RW)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr(fire && is_end), .we(we),
    .waddr(ins_dst), .wdata(wdata),
    .raddr_a(ins_src_a), .raddr_b(ins_src_b),
    .rdata_a(rd_a), .rdata_b(rd_b), .rdef_a(def_a), .rdef_b(def_b)
  );

  lcg_meta_fu #(.PAT_W(PAT_W)) u_fu (
    .op(ins_op), .a(rd_a), .b(rd_b), .cin(cin_pat),
    .res(fu_res), .gen(fu_gen), .prop(fu_prop)
  );

  // Rule checks for the instruction on the port
  always_comb begin
    op_err = 1'b0;
    wr     = 1'b0;
    wdata  = fu_res;
    case (ins_op)
      OP_AND, OP_ORR, OP_EOR: begin
        op_err = !(def_a && def_b);
        wr     = 1'b1;
      end
      OP_ADD: begin
        op_err = !(def_a && def_b) || (used >= NV_L) || (add_cnt >= MA_L);
        wr     = 1'b1;
      end
      OP_SEED: begin
        op_err = (used >= NV_L);
        wr     = 1'b1;
        wdata  = seed_pat;
      end
      OP_END:  op_err = !(def_a && def_b);
      default: op_err = 1'b1;
    endcase
  end

  assign we = fire && wr && !op_err && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      err_o   <= 1'b0;
      in_cnt  <= '0;
      add_cnt <= '0;
      g_q     <= '0;
      p_q     <= '0;
      go_q    <= '0;
      po_q    <= '0;
      out0_q  <= '0;
      out1_q  <= '0;
    end else begin
      done_q <= fire && is_end;
      if (fire) begin
        if (is_end) begin
          err_o <= err_q || op_err;
          if (err_q || op_err) begin
            out0_q <= '0;
            out1_q <= '0;
            go_q   <= '0;
            po_q   <= '0;
          end else begin
            out0_q <= rd_a;
            out1_q <= rd_b;
            go_q   <= g_q;
            po_q   <= p_q;
          end
          err_q   <= 1'b0;
          in_cnt  <= '0;
          add_cnt <= '0;
          g_q     <= '0;
          p_q     <= '0;
        end else if (!err_q) begin
          if (op_err) begin
            err_q <= 1'b1;
          end else begin
            if (ins_op == OP_SEED) in_cnt <= in_cnt + CW'(1);
            if (ins_op == OP_ADD) begin
              add_cnt <= add_cnt + CW'(1);
              for (int n = 0; n < MAX_ADD; n++) begin
                if (CW'(n) == add_cnt) begin
                  g_q[n] <= fu_gen;
                  p_q[n] <= fu_prop;
                end
              end
            end
          end
        end
      end
    end
  end

  assign done     = done_q;
  assign err      = err_o;
  assign cfg_out0 = out0_q;
  assign cfg_out1 = out1_q;
  assign cfg_g    = go_q;
  assign cfg_p    = po_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_op == OP_END) |=> done);

  // R10
  err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (cfg_out0 == '0 && cfg_out1 == '0 && cfg_g == '0 && cfg_p == '0));

  // R8
  add_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_cnt <= MA_L);

  // R8
  var_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= NV_L);
endmodule

// File: tb/lut_cfg_gen_tb_top.sv
module lut_cfg_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int MA = 2;
  localparam int NR = 16;
  localparam int PW = 1 << NV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [2:0] ins_op = '0;
  logic [3:0] ins_dst = '0, ins_src_a = '0, ins_src_b = '0;
  logic ins_ready, done, err;
  logic [PW-1:0] cfg_out0, cfg_out1;
  logic [MA*PW-1:0] cfg_g, cfg_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_cfg_gen #(.NUM_VARS(NV), .MAX_ADD(MA), .NUM_REGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_dst(ins_dst), .ins_src_a(ins_src_a), .ins_src_b(ins_src_b),
    .done(done), .err(err), .cfg_out0(cfg_out0), .cfg_out1(cfg_out1),
    .cfg_g(cfg_g), .cfg_p(cfg_p)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit running = 0;
  bit finished = 0;
  string cur_req = "R1";

  function automatic void check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [PW-1:0] varpat(int k);
    logic [PW-1:0] r;
    for (int j = 0; j < PW; j++) r[j] = ((j >> k) & 1) == 1;
    return r;
  endfunction

  // Behavioural reference model
  logic [PW-1:0] m_reg [NR];
  bit m_def [NR];
  int m_in = 0, m_add = 0;
  bit m_err = 0;
  logic [PW-1:0] m_g [MA];
  logic [PW-1:0] m_p [MA];
  bit e_done = 0, e_err = 0, m_fire = 0;
  logic [PW-1:0] e_o0 = '0, e_o1 = '0;
  logic [MA*PW-1:0] e_g = '0, e_p = '0;

  function automatic void clear_sub();
    for (int i = 0; i < NR; i++) m_def[i] = 0;
    for (int i = 0; i < MA; i++) begin m_g[i] = '0; m_p[i] = '0; end
    m_in = 0; m_add = 0; m_err = 0;
  endfunction

  function automatic void model_step(int op, int d, int a, int b);
    logic [PW-1:0] va, vb;
    bit bad;
    va = m_reg[a];
    vb = m_reg[b];
    case (op)
      0, 1, 2: bad = !(m_def[a] && m_def[b]);
      3: bad = !(m_def[a] && m_def[b]) || (m_in + m_add >= NV) || (m_add >= MA);
      4: bad = (m_in + m_add >= NV);
      5: bad = !(m_def[a] && m_def[b]);
      default: bad = 1;
    endcase
    if (op == 5) begin
      e_done = 1;
      e_err = m_err || bad;
      if (e_err) begin
        e_o0 = '0; e_o1 = '0; e_g = '0; e_p = '0;
      end else begin
        e_o0 = va; e_o1 = vb;
        for (int i = 0; i < MA; i++) begin
          e_g[i*PW +: PW] = m_g[i];
          e_p[i*PW +: PW] = m_p[i];
        end
      end
      clear_sub();
    end else if (!m_err) begin
      if (bad) m_err = 1;
      else begin
        case (op)
          0: m_reg[d] = va & vb;
          1: m_reg[d] = va | vb;
          2: m_reg[d] = va ^ vb;
          3: begin
            m_g[m_add] = va & vb;
            m_p[m_add] = va ^ vb;
            m_reg[d] = va ^ vb ^ varpat(NV - 1 - m_add);
            m_add++;
          end
          default: begin
            m_reg[d] = varpat(m_in);
            m_in++;
          end
        endcase
        m_def[d] = 1;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      clear_sub();
      e_done = 0; e_err = 0; e_o0 = '0; e_o1 = '0; e_g = '0; e_p = '0;
    end else begin
      m_fire = ins_valid && !e_done;
      e_done = 0;
      if (m_fire) model_step(int'(ins_op), int'(ins_dst), int'(ins_src_a), int'(ins_src_b));
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (running && !finished) begin
      check("R2", "ins_ready", 64'(ins_ready), 64'(!e_done));
      check("R6", "done", 64'(done), 64'(e_done));
      check("R10", "err", 64'(err), 64'(e_err));
      check(cur_req, "cfg_out0", 64'(cfg_out0), 64'(e_o0));
      check(cur_req, "cfg_out1", 64'(cfg_out1), 64'(e_o1));
      check(cur_req, "cfg_g", 64'(cfg_g), 64'(e_g));
      check(cur_req, "cfg_p", 64'(cfg_p), 64'(e_p));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic send(int op, int d, int a, int b);
    bit r;
    ins_op = 3'(op); ins_dst = 4'(d); ins_src_a = 4'(a); ins_src_b = 4'(b);
    ins_valid = 1'b1;
    forever begin
      r = ins_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic finish_sub(int a, int b, logic [PW-1:0] x0, logic [PW-1:0] x1,
                            logic [MA*PW-1:0] xg, logic [MA*PW-1:0] xp, bit xerr, string tag);
    send(5, 0, a, b);
    check(tag, "done pulse", 64'(done), 64'd1);
    check(tag, "err", 64'(err), 64'(xerr));
    check(tag, "out0", 64'(cfg_out0), 64'(x0));
    check(tag, "out1", 64'(cfg_out1), 64'(x1));
    check(tag, "g", 64'(cfg_g), 64'(xg));
    check(tag, "p", 64'(cfg_p), 64'(xp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ins_ready", 64'(ins_ready), 64'd1);
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "err", 64'(err), 64'd0);
    check("R1", "cfg", 64'(cfg_out0 | cfg_out1 | cfg_g[15:0] | cfg_p[15:0]), 64'd0);
    rst_n = 1'b1;
    running = 1;

    // R4 R5: AND, ADD, XOR chain
    cur_req = "R4";
    send(4, 1, 0, 0);
    send(4, 2, 0, 0);
    send(0, 3, 1, 2);
    send(3, 4, 1, 2);
    send(2, 5, 3, 4);
    finish_sub(5, 4, 16'h11EE, 16'h9966, 32'h0000_8888, 32'h0000_6666, 0, "R4");
    // R2: stalled during the done cycle, consumed once afterwards
    check("R2", "ready low in done cycle", 64'(ins_ready), 64'd0);
    cur_req = "R6";
    send(4, 7, 0, 0);
    send(2, 8, 7, 7);
    finish_sub(7, 8, 16'hAAAA, 16'h0000, 32'h0, 32'h0, 0, "R6");

    // R3: four seeds fill the variables
    cur_req = "R3";
    send(4, 9, 0, 0);
    send(4, 10, 0, 0);
    send(4, 11, 0, 0);
    send(4, 12, 0, 0);
    finish_sub(11, 12, 16'hF0F0, 16'hFF00, 32'h0, 32'h0, 0, "R3");
    finish_sub(9, 10, 16'h0, 16'h0, 32'h0, 32'h0, 1, "R7");

    // R5: two carry stages and OR
    cur_req = "R5";
    send(4, 0, 0, 0);
    send(4, 1, 0, 0);
    send(3, 2, 0, 1);
    send(3, 3, 2, 0);
    send(1, 4, 3, 1);
    finish_sub(4, 3, 16'hCFFC, 16'hC33C, 32'h8822_8888, 32'h33CC_6666, 0, "R5");

    // R7 R10: undefined source, later instructions ignored
    cur_req = "R10";
    send(0, 3, 1, 2);
    send(4, 1, 0, 0);
    finish_sub(1, 1, 16'h0, 16'h0, 32'h0, 32'h0, 1, "R10");

    // R8: third add exceeds the stage limit
    cur_req = "R8";
    send(4, 0, 0, 0);
    send(3, 1, 0, 0);
    send(3, 2, 1, 0);
    send(3, 3, 2, 0);
    finish_sub(2, 2, 16'h0, 16'h0, 32'h0, 32'h0, 1, "R8");
    // R8: fifth seed overruns the variables
    for (int i = 0; i < 5; i++) send(4, i, 0, 0);
    finish_sub(0, 1, 16'h0, 16'h0, 32'h0, 32'h0, 1, "R8");

    // R9: illegal opcode
    cur_req = "R9";
    send(4, 0, 0, 0);
    send(6, 1, 0, 0);
    finish_sub(0, 0, 16'h0, 16'h0, 32'h0, 32'h0, 1, "R9");

    // R10: error cleared for the next subgraph
    cur_req = "R10";
    send(4, 1, 0, 0);
    send(4, 2, 0, 0);
    send(0, 3, 1, 2);
    send(3, 4, 1, 2);
    send(2, 5, 3, 4);
    finish_sub(5, 4, 16'h11EE, 16'h9966, 32'h0000_8888, 32'h0000_6666, 0, "R10");
    ins_valid = 1'b0;
    cur_req = "R6";
    repeat (4) @(negedge clk);
    check("R6", "held out0", 64'(cfg_out0), 64'h11EE);
    check("R6", "done idle", 64'(done), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule